// File: doc/BRIEF.md
# Halt-State Power Sequencer

This block decides how a small microcontroller core enters and leaves its deepest low-power state. Each clock it looks at a decoded halt request and a decoded wait request from the instruction decoder. In the halt state it shuts the oscillator down. In the lighter wait state the oscillator keeps running and only the core clock is gated. After a halt, every wake-up restarts the oscillator and holds the core for a fixed settling time, measured by a counter. The core then resumes with a one-cycle vector-fetch pulse that tells it to load either the reset handler or the interrupt handlers that caused the wake.

A running watchdog normally forbids the halt state, so a halt request becomes a wait request. The exception is when the external-stop option is set and the NMI pin is high at the request. The halt then goes ahead and the watchdog is held frozen until the halt ends. Reset sources always take priority over interrupts when the vector is chosen. Wake events that arrive during the settling time are collected so that none is lost.

Top module: `halt_seq_ctrl`

## Requirements
- R1: When `rst_n` is released, the block settles first: `osc_en`=1 and `core_clk_en`=0 for exactly SETTLE_CYCLES (default 2048) clocks. Then `vec_fetch` pulses with `vec_reset`=1.
- R2: In run, a `stop_req` with `wdg_active`=0 enters the halt state at the next clock edge: `osc_en`=0, `core_clk_en`=0, `wdg_freeze`=0, `wait_mode`=0.
- R3: In run, a `stop_req` with `wdg_active`=1 and not (`ext_stop_opt`=1 and `nmi_pin`=1) enters the wait state instead: `wait_mode`=1, `osc_en`=1, `core_clk_en`=0.
- R4: In run, a `stop_req` with `wdg_active`=1, `ext_stop_opt`=1 and `nmi_pin`=1 enters the halt state. `wdg_freeze` is 1 for every cycle of that halt.
- R5: In run, a `wait_req` enters the wait state (`wait_mode`=1, `osc_en`=1, `core_clk_en`=0).
- R6: In the halt state, any bit of `rst_src` or `irq` starts the settling time at the next edge. From that edge on, `osc_en`=1 and `wdg_freeze`=0. The settling time lasts SETTLE_CYCLES clocks. Then comes a single-cycle `vec_fetch`, and after it the run state (`core_clk_en`=1). From the negedge where the wake is driven, the fetch is seen SETTLE_CYCLES+1 clocks later.
- R7: In the wait state, any bit of `rst_src` or `irq` makes `vec_fetch` pulse at the next edge, with no settling time.
- R8: At the fetch, `vec_irq` is the OR of every `irq` bit seen from the wake edge to the end of the settling time. Bit i stands for line i.
- R9: If any reset source was seen during the wake sequence, the fetch shows `vec_reset`=1 and `vec_irq`=0.
- R10: In run, any `rst_src` bit makes `vec_fetch` pulse at the next edge with `vec_reset`=1.
- R11: In run, `irq` has no effect on any output.
- R12: In run, the order of priority is `rst_src` first, then `stop_req`, then `wait_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stop_req | input | 1 | Decoded halt instruction, one cycle |
| wait_req | input | 1 | Decoded wait instruction, one cycle |
| wdg_active | input | 1 | Watchdog is running (enabled by hardware or by software) |
| ext_stop_opt | input | 1 | Option bit that allows a halt while the watchdog runs |
| nmi_pin | input | 1 | Level of the non-maskable interrupt pin |
| rst_src | input | NRST (3) | Reset sources: watchdog, low-voltage detect, reset pin |
| irq | input | IRQ_W (4) | Enabled wake interrupt lines |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| wdg_freeze | output | 1 | Holds the watchdog counter |
| wait_mode | output | 1 | Wait state indication |
| vec_fetch | output | 1 | One-cycle pulse that starts the vector fetch |
| vec_reset | output | 1 | The vector at this fetch is the reset handler |
| vec_irq | output | IRQ_W (4) | Interrupt lines to service at this fetch |

## Verification
Every output is decoded from registered state only, so a wrong state or a wrong choice of transition shows up on the oscillator, clock-gate, freeze or wait outputs at the very next negedge. The exception is a settling counter that is off by a few counts: it only shows as a vector-fetch pulse that comes early or late, about 2048 cycles after the wake. Errors in the wake-event latch show only at the fetch pulse, as a wrong vector mask or a wrong reset flag. The bench therefore compares each output against a behavioural model on every cycle, and also counts the exact length of the settling time.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_WAIT   = 3'd1,
    PS_STOP   = 3'd2,
    PS_SETTLE = 3'd3,
    PS_FETCH  = 3'd4
  } pstate_t;

  // A halt is honoured when the watchdog is idle, or when the option
  // bit and the NMI level together override it.
  function automatic logic stop_permitted(input logic wdg_on,
                                          input logic ext_opt,
                                          input logic nmi_lvl);
    return !wdg_on || (ext_opt && nmi_lvl);
  endfunction

  // Terminal count of a settling counter that runs from 0 to cycles-1.
  function automatic logic count_is_last(input int unsigned cnt,
                                         input int unsigned cycles);
    return cnt == cycles - 1;
  endfunction

endpackage

// File: rtl/halt_decide.sv
module halt_decide
  import halt_seq_pkg::*;
(
  input  logic stop_req,
  input  logic wait_req,
  input  logic wdg_active,
  input  logic ext_stop_opt,
  input  logic nmi_pin,
  output logic go_stop,
  output logic go_wait,
  output logic freeze_arm
);
  logic permit;

  always_comb begin
    permit     = stop_permitted(wdg_active, ext_stop_opt, nmi_pin);
    go_stop    = stop_req && permit;
    go_wait    = !go_stop && (wait_req || stop_req);
    freeze_arm = go_stop && wdg_active;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer
  import halt_seq_pkg::*;
#(
  parameter int unsigned CYCLES = 2048
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  output logic                       done,
  output logic [$clog2(CYCLES)-1:0]  count
);
  localparam int W = $clog2(CYCLES);

  assign done = run && count_is_last(int'(count), CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (!run)      count <= '0;
    else if (done)      count <= '0;
    else                count <= count + W'(1);
  end

  assert_count_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> count == '0);
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> count == $past(count) + W'(1));
endmodule

// File: rtl/wake_latch.sv
module wake_latch #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic             rst_any,
  input  logic [IRQ_W-1:0] irq_in,
  output logic             pend_rst,
  output logic [IRQ_W-1:0] pend_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rst <= 1'b1;
      pend_irq <= '0;
    end else if (clear) begin
      pend_rst <= 1'b0;
      pend_irq <= '0;
    end else if (capture) begin
      pend_rst <= pend_rst | rst_any;
      pend_irq <= pend_irq | irq_in;
    end
  end

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rst && !clear) |=> pend_rst);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |=> ((pend_irq & $past(pend_irq)) == $past(pend_irq)));
endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
  import halt_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2048,
  parameter int          IRQ_W         = 4,
  parameter int          NRST          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             wdg_active,
  input  logic             ext_stop_opt,
  input  logic             nmi_pin,
  input  logic [NRST-1:0]  rst_src,
  input  logic [IRQ_W-1:0] irq,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             wdg_freeze,
  output logic             wait_mode,
  output logic             vec_fetch,
  output logic             vec_reset,
  output logic [IRQ_W-1:0] vec_irq
);
  localparam int CW = $clog2(SETTLE_CYCLES);

  pstate_t          state, state_nx;
  logic             frz_q;
  logic             go_stop, go_wait, freeze_arm;
  logic             rst_any, wake_any, settle_done;
  logic             pend_rst;
  logic [IRQ_W-1:0] pend_irq, irq_gated;
  logic [CW-1:0]    settle_cnt;

  assign rst_any   = |rst_src;
  assign wake_any  = rst_any || (|irq);
  assign irq_gated = (state == PS_RUN) ? '0 : irq;

  halt_decide u_decide (
    .stop_req(stop_req), .wait_req(wait_req), .wdg_active(wdg_active),
    .ext_stop_opt(ext_stop_opt), .nmi_pin(nmi_pin),
    .go_stop(go_stop), .go_wait(go_wait), .freeze_arm(freeze_arm)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == PS_SETTLE),
    .done(settle_done), .count(settle_cnt)
  );

  wake_latch #(.IRQ_W(IRQ_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .capture(state != PS_FETCH), .clear(state == PS_FETCH),
    .rst_any(rst_any), .irq_in(irq_gated),
    .pend_rst(pend_rst), .pend_irq(pend_irq)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_RUN: begin
        if (rst_any)      state_nx = PS_FETCH;
        else if (go_stop) state_nx = PS_STOP;
        else if (go_wait) state_nx = PS_WAIT;
      end
      PS_WAIT:   if (wake_any)    state_nx = PS_FETCH;
      PS_STOP:   if (wake_any)    state_nx = PS_SETTLE;
      PS_SETTLE: if (settle_done) state_nx = PS_FETCH;
      PS_FETCH:                   state_nx = PS_RUN;
      default:                    state_nx = PS_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_SETTLE;
      frz_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == PS_RUN && !rst_any && go_stop) frz_q <= freeze_arm;
      else if (state != PS_STOP)                  frz_q <= 1'b0;
      else if (wake_any)                          frz_q <= 1'b0;
    end
  end

  assign osc_en      = (state != PS_STOP);
  assign core_clk_en = (state == PS_RUN) || (state == PS_FETCH);
  assign wdg_freeze  = (state == PS_STOP) && frz_q;
  assign wait_mode   = (state == PS_WAIT);
  assign vec_fetch   = (state == PS_FETCH);
  assign vec_reset   = vec_fetch && pend_rst;
  assign vec_irq     = (vec_fetch && !pend_rst) ? pend_irq : '0;

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && !rst_any && go_stop) |=> (!osc_en && !core_clk_en));
  assert_stop_to_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && !rst_any && stop_req && !go_stop) |=> (wait_mode && osc_en));
  assert_freeze_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_freeze && !wake_any) |=> wdg_freeze);
  assert_exit_unfreeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_STOP && wake_any) |=> (osc_en && !wdg_freeze && !core_clk_en));
  assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> (!vec_fetch && core_clk_en));
  assert_wait_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAIT && wake_any) |=> vec_fetch);
  assert_run_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && rst_any) |=> (vec_fetch && vec_reset));
  assert_reset_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_reset |-> (vec_irq == '0));
endmodule

// File: tb/test_halt_seq_ctrl.sv
module test_halt_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 2048;
  localparam int IW = 4;
  localparam int NR = 3;

  logic clk = 0, rst_n = 0;
  logic stop_req = 0, wait_req = 0, wdg_active = 0, ext_stop_opt = 0, nmi_pin = 0;
  logic [NR-1:0] rst_src = '0;
  logic [IW-1:0] irq = '0;
  logic osc_en, core_clk_en, wdg_freeze, wait_mode, vec_fetch, vec_reset;
  logic [IW-1:0] vec_irq;

  int checks = 0, fails = 0, cyc = 0, k = 0;
  int m_st, m_cnt;
  logic m_prst, m_frz;
  logic [IW-1:0] m_pirq;

  halt_seq_ctrl #(.SETTLE_CYCLES(N), .IRQ_W(IW), .NRST(NR)) i_halt_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .wdg_active(wdg_active), .ext_stop_opt(ext_stop_opt), .nmi_pin(nmi_pin),
    .rst_src(rst_src), .irq(irq), .osc_en(osc_en), .core_clk_en(core_clk_en),
    .wdg_freeze(wdg_freeze), .wait_mode(wait_mode), .vec_fetch(vec_fetch),
    .vec_reset(vec_reset), .vec_irq(vec_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: 0 run, 1 wait, 2 halt, 3 settling, 4 fetch
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 3; m_cnt = 0; m_prst = 1; m_pirq = '0; m_frz = 0;
    end else begin
      case (m_st)
        0: if (|rst_src) begin m_prst = 1; m_st = 4; end
           else if (stop_req && (!wdg_active || (ext_stop_opt && nmi_pin))) begin
             m_st = 2; m_frz = wdg_active;
           end else if (stop_req || wait_req) m_st = 1;
        1: if (|rst_src || |irq) begin
             m_prst = m_prst | (|rst_src); m_pirq = m_pirq | irq; m_st = 4;
           end
        2: if (|rst_src || |irq) begin
             m_prst = m_prst | (|rst_src); m_pirq = m_pirq | irq;
             m_st = 3; m_cnt = 0; m_frz = 0;
           end
        3: begin
             m_prst = m_prst | (|rst_src); m_pirq = m_pirq | irq;
             if (m_cnt == N - 1) m_st = 4; else m_cnt = m_cnt + 1;
           end
        default: begin m_prst = 0; m_pirq = '0; m_st = 0; end
      endcase
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      case (m_st)
        0: tg = "R11"; 1: tg = "R3"; 2: tg = "R2"; 3: tg = "R6"; default: tg = "R9";
      endcase
      chk({tg, " osc_en"},      osc_en,      m_st != 2);
      chk({tg, " core_clk_en"}, core_clk_en, m_st == 0 || m_st == 4);
      chk({tg, " wdg_freeze"},  wdg_freeze,  m_st == 2 && m_frz);
      chk({tg, " wait_mode"},   wait_mode,   m_st == 1);
      chk({tg, " vec_fetch"},   vec_fetch,   m_st == 4);
      chk({tg, " vec_reset"},   vec_reset,   m_st == 4 && m_prst);
      chk({tg, " vec_irq"},     vec_irq,     (m_st == 4 && !m_prst) ? m_pirq : '0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R6 watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_fetch(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!vec_fetch && n < N + 10);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1 reset osc_en", osc_en, 1);
    chk("R1 reset core gated", core_clk_en, 0);
    rst_n = 1;
    wait_fetch(k);
    chk("R1 settle length", k, N);
    chk("R1 reset vector", vec_reset, 1);
    idle(2);

    // R2 plain halt, R8 latch of a late interrupt
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk("R2 osc off", osc_en, 0);
    chk("R2 no freeze", wdg_freeze, 0);
    idle(5);
    irq = 4'b0100; wait_fetch(k);
    chk("R6 delay length", k, N + 1);
    chk("R8 irq mask", vec_irq, 4'b0100);
    idle(2);
    stop_req = 1; @(negedge clk); stop_req = 0; irq = '0;
    idle(3);
    irq = 4'b0100; @(negedge clk); irq = '0;
    chk("R6 unfrozen osc on", osc_en, 1);
    idle(100);
    irq = 4'b0001; @(negedge clk); irq = '0;
    wait_fetch(k);
    chk("R8 merged mask", vec_irq, 4'b0101);
    idle(2);

    // R3 watchdog forces wait, R7 wake without delay
    wdg_active = 1;
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk("R3 wait substitution", wait_mode, 1);
    chk("R3 osc stays on", osc_en, 1);
    idle(4);
    irq = 4'b0010; @(negedge clk); irq = '0;
    chk("R7 immediate fetch", vec_fetch, 1);
    chk("R7 vector", vec_irq, 4'b0010);
    idle(2);
    ext_stop_opt = 1; nmi_pin = 0;
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk("R3 option without nmi", wait_mode, 1);
    rst_src = 3'b100; @(negedge clk); rst_src = '0;
    chk("R7 reset from wait", vec_reset, 1);
    idle(2);

    // R4 frozen halt, R9 reset beats interrupts
    nmi_pin = 1;
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk("R4 halt honoured", osc_en, 0);
    chk("R4 freeze", wdg_freeze, 1);
    idle(20);
    chk("R4 freeze held", wdg_freeze, 1);
    rst_src = 3'b001; irq = 4'b1000; @(negedge clk); rst_src = '0; irq = '0;
    chk("R6 freeze released", wdg_freeze, 0);
    wait_fetch(k);
    chk("R9 reset flag", vec_reset, 1);
    chk("R9 irq masked", vec_irq, 0);
    idle(2);
    wdg_active = 0; ext_stop_opt = 0; nmi_pin = 0;

    // R5 wait instruction
    wait_req = 1; @(negedge clk); wait_req = 0;
    chk("R5 wait entered", wait_mode, 1);
    chk("R5 core gated", core_clk_en, 0);
    irq = 4'b1000; @(negedge clk); irq = '0;
    chk("R7 fetch from wait", vec_fetch, 1);
    idle(2);

    // R11 interrupts ignored in run, R10 reset in run
    irq = 4'b1111; @(negedge clk); irq = '0;
    chk("R11 no fetch", vec_fetch, 0);
    chk("R11 still running", core_clk_en, 1);
    rst_src = 3'b010; @(negedge clk); rst_src = '0;
    chk("R10 fetch", vec_fetch, 1);
    chk("R10 reset", vec_reset, 1);
    idle(2);

    // R12 priorities
    stop_req = 1; wait_req = 1; rst_src = 3'b100; @(negedge clk);
    stop_req = 0; wait_req = 0; rst_src = '0;
    chk("R12 reset first", vec_reset, 1);
    idle(2);
    stop_req = 1; wait_req = 1; @(negedge clk); stop_req = 0; wait_req = 0;
    chk("R12 halt before wait", osc_en, 0);
    chk("R12 not wait", wait_mode, 0);
    irq = 4'b0001; @(negedge clk); irq = '0;
    wait_fetch(k);
    chk("R6 second delay", k, N);
    idle(3);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule